// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block produces the individual time slots of a single-wire open-drain bus. It handles a bus reset with presence detection, a write-0 slot, a write-1 slot and a read slot, each built from fixed windows: a driven-low window, an optional released window that ends at the sampling instant, and a released tail window. A free-running divider of the system clock yields a microsecond tick. The divider restarts at every phase boundary, so each window lasts an exact number of clock cycles. Every window length is multiplied by an integer timing coefficient.

A host issues one slot at a time on a valid/ready command port. It receives a one-cycle done pulse together with the result bit. The block only ever drives the line low through an open-drain enable and otherwise releases it. It reads the line through a two-flop synchronizer. Byte assembly, strong pull-up control, device search and CRC are left to the logic above.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset the line is released (`owDriveLow`=0), `cmdReady`=1 and `rspValid`=0.
- R2: A write with `cmdOp`=2'b01 and `cmdBit`=1 drives the line low for 6 us, then releases it for 64 us, and returns 0 whatever the line level is.
- R3: A write with `cmdOp`=2'b01 and `cmdBit`=0 drives low for 60 us, then releases for 10 us, and returns 0.
- R4: A read (`cmdOp`=2'b11) drives low for 6 us and releases the line. It samples the synchronized line 9 us after release, completes 55 us later, and returns the sampled level.
- R5: A bus reset (`cmdOp`=2'b00) drives low for 480 us and samples 70 us after release. It then waits a further 410 us, so the slot totals 960 us.
- R6: The reset result is 0 when the line is low at the presence sample (a device answered) and 1 when it is high.
- R7: A touch (`cmdOp`=2'b10) with `cmdBit`=1 runs a read slot and returns the sampled level. With `cmdBit`=0 it runs a write-0 slot and returns 0.
- R8: All window lengths scale by the parameter TIME_COEF. One microsecond is CLKS_PER_US clock cycles, and every window is measured from the accepting clock edge.
- R9: `cmdReady` is low from the cycle after acceptance until the slot completes. A request presented while busy has no effect.
- R10: `rspValid` is a one-cycle pulse in the first cycle that `cmdReady` is high again, and `rspBit` is valid with it.
- R11: The line is driven low only during the low window of a slot and is released at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Slot request valid |
| cmdReady | output | 1 | Engine idle, request accepted when valid |
| cmdOp | input | 2 | 00 bus reset, 01 write, 10 touch, 11 read |
| cmdBit | input | 1 | Data bit for write and touch |
| rspValid | output | 1 | One-cycle slot completion pulse |
| rspBit | output | 1 | Sampled bit, presence result, or 0 for writes |
| owDriveLow | output | 1 | Open-drain enable: 1 pulls the line low |
| owIn | input | 1 | Asynchronous line level |

## Verification
Let U be CLKS_PER_US times TIME_COEF and take the accepting edge as cycle 0. The low window then covers cycles 0 to low*U-1. The done pulse and the return of ready come exactly (low+wait+tail)*U cycles after acceptance. The sampled level is the line as it stood two clock edges before the sampling edge, at (low+wait)*U. The bench counts cycles from the accepting edge and samples on the falling clock edge. It places the device's pull window several microseconds around or well ahead of the sampling instant, so the two-flop delay never decides an expected bit. Two instances with coefficients 1 and 2 run the same stimulus, and their expected durations differ by exactly that factor.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_TOUCH = 2'b10,
    OP_READ  = 2'b11
  } cmdOpT;

  typedef enum logic [1:0] {
    SLOT_RST,
    SLOT_W0,
    SLOT_W1,
    SLOT_RD
  } slotT;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_TAIL
  } phaseT;

  localparam int unsigned US_FIELD_W = 9;
  localparam int unsigned LONGEST_US = 480;

  // strobes from control to datapath
  typedef struct packed {
    logic                  start;    // new slot accepted
    logic                  restart;  // restart tick divider and window counter
    logic                  driveLow; // pull the line low
    logic                  capture;  // sample synchronized line
    logic                  finish;   // slot complete
    logic [US_FIELD_W-1:0] phaseUs;  // current window length, unscaled
  } strobeT;

  function automatic logic [US_FIELD_W-1:0] lowUs(slotT s);
    case (s)
      SLOT_RST: return 9'd480;
      SLOT_W0:  return 9'd60;
      default:  return 9'd6;
    endcase
  endfunction

  function automatic logic [US_FIELD_W-1:0] waitUs(slotT s);
    case (s)
      SLOT_RST: return 9'd70;
      SLOT_RD:  return 9'd9;
      default:  return 9'd0;
    endcase
  endfunction

  function automatic logic [US_FIELD_W-1:0] tailUs(slotT s);
    case (s)
      SLOT_RST: return 9'd410;
      SLOT_W0:  return 9'd10;
      SLOT_W1:  return 9'd64;
      default:  return 9'd55;
    endcase
  endfunction

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = $clog2(CLKS_PER_US + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_US - 1);

  logic [CNT_W-1:0] divCount;

  assign tick = (divCount == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) divCount <= '0;
    else if (tick)      divCount <= '0;
    else                divCount <= divCount + 1'b1;
  end
endmodule

// File: rtl/ow_slot_dp.sv
module ow_slot_dp
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int TIME_COEF   = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  strobeT strobes,
  input  logic   owIn,
  output logic   phaseEnd,
  output logic   owDriveLow,
  output logic   rspValid,
  output logic   rspBit
);
  localparam int US_W = $clog2(LONGEST_US * TIME_COEF + 1);

  logic            tick;
  logic [US_W-1:0] usCount;
  logic [US_W-1:0] lastUs;
  logic            syncA, syncB;
  logic            sampled;

  ow_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .restart(strobes.restart),
    .tick   (tick)
  );

  assign lastUs   = US_W'(32'(strobes.phaseUs) * 32'(TIME_COEF) - 32'd1);
  assign phaseEnd = tick && (usCount == lastUs);

  always_ff @(posedge clk) begin
    if (rst || strobes.restart) usCount <= '0;
    else if (tick)              usCount <= usCount + 1'b1;
  end

  // two-flop synchronizer, idle level is high
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= owIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.start) sampled <= 1'b0;
    else if (strobes.capture) sampled <= syncB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspBit   <= 1'b0;
    end else begin
      rspValid <= strobes.finish;
      if (strobes.finish) rspBit <= sampled;
    end
  end

  assign owDriveLow = strobes.driveLow;
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       phaseEnd,
  output logic       cmdReady,
  output strobeT     strobes
);
  phaseT phase;
  slotT  slot;
  logic  accept;

  function automatic slotT decodeSlot(logic [1:0] op, logic b);
    case (cmdOpT'(op))
      OP_RESET: return SLOT_RST;
      OP_WRITE: return b ? SLOT_W1 : SLOT_W0;
      OP_TOUCH: return b ? SLOT_RD : SLOT_W0;
      default:  return SLOT_RD;
    endcase
  endfunction

  assign cmdReady = (phase == PH_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    strobes          = '0;
    strobes.start    = accept;
    strobes.restart  = accept || ((phase != PH_IDLE) && phaseEnd);
    strobes.driveLow = (phase == PH_LOW);
    strobes.capture  = (phase == PH_WAIT) && phaseEnd;
    strobes.finish   = (phase == PH_TAIL) && phaseEnd;
    case (phase)
      PH_LOW:  strobes.phaseUs = lowUs(slot);
      PH_WAIT: strobes.phaseUs = waitUs(slot);
      PH_TAIL: strobes.phaseUs = tailUs(slot);
      default: strobes.phaseUs = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      slot  <= SLOT_RST;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          slot  <= decodeSlot(cmdOp, cmdBit);
          phase <= PH_LOW;
        end
        PH_LOW: if (phaseEnd)
          phase <= (slot == SLOT_RD || slot == SLOT_RST) ? PH_WAIT : PH_TAIL;
        PH_WAIT: if (phaseEnd) phase <= PH_TAIL;
        default: if (phaseEnd) phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int TIME_COEF   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  output logic       rspValid,
  output logic       rspBit,
  output logic       owDriveLow,
  input  logic       owIn
);
  strobeT strobes;
  logic   phaseEnd;

  ow_slot_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .cmdBit  (cmdBit),
    .phaseEnd(phaseEnd),
    .cmdReady(cmdReady),
    .strobes (strobes)
  );

  ow_slot_dp #(.CLKS_PER_US(CLKS_PER_US), .TIME_COEF(TIME_COEF)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .owIn      (owIn),
    .phaseEnd  (phaseEnd),
    .owDriveLow(owDriveLow),
    .rspValid  (rspValid),
    .rspBit    (rspBit)
  );
endmodule

// File: rtl/ow_slot_checker.sv
module ow_slot_checker #(
  parameter int CLKS_PER_US = 50,
  parameter int TIME_COEF   = 1
) (
  input logic clk,
  input logic rst,
  input logic cmdValid,
  input logic cmdReady,
  input logic owDriveLow,
  input logic rspValid
);
  localparam int unsigned U = CLKS_PER_US * TIME_COEF;

  int unsigned lowRun;
  int unsigned busyRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowRun  <= 0;
      busyRun <= 0;
    end else begin
      lowRun  <= owDriveLow ? lowRun + 1 : 0;
      busyRun <= cmdReady ? 0 : busyRun + 1;
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady) |=> (!cmdReady && owDriveLow)); // R9
  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    owDriveLow |-> !cmdReady); // R11
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> cmdReady); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R10
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(owDriveLow) |-> (lowRun == 6*U || lowRun == 60*U || lowRun == 480*U)); // R2
  AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (busyRun == 70*U || busyRun == 960*U)); // R5
endmodule

bind ow_slot_engine ow_slot_checker #(
  .CLKS_PER_US(CLKS_PER_US),
  .TIME_COEF  (TIME_COEF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .owDriveLow(owDriveLow),
  .rspValid  (rspValid)
);

// File: tb/tb_ow_slot_engine.sv
module tb_ow_slot_engine;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int UA         = CPU;      // cycles per us, coefficient 1
  localparam int UB         = CPU * 2;  // cycles per us, coefficient 2

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic       cmdBit = 1'b0;
  logic       pullA = 1'b0, pullB = 1'b0;
  logic       readyA, rspValidA, rspBitA, driveA, busA;
  logic       readyB, rspValidB, rspBitB, driveB, busB;

  assign busA = !(driveA || pullA);
  assign busB = !(driveB || pullB);

  ow_slot_engine #(.CLKS_PER_US(CPU), .TIME_COEF(1)) dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(readyA),
    .cmdOp(cmdOp), .cmdBit(cmdBit), .rspValid(rspValidA), .rspBit(rspBitA),
    .owDriveLow(driveA), .owIn(busA));

  ow_slot_engine #(.CLKS_PER_US(CPU), .TIME_COEF(2)) dutScaled (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(readyB),
    .cmdOp(cmdOp), .cmdBit(cmdBit), .rspValid(rspValidB), .rspBit(rspBitB),
    .owDriveLow(driveB), .owIn(busB));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slot kinds: 0 reset, 1 write-0, 2 write-1, 3 read
  function automatic int kindOf(int op, bit b);
    case (op)
      0: return 0;
      1: return b ? 2 : 1;
      2: return b ? 3 : 1;
      default: return 3;
    endcase
  endfunction
  function automatic int lowOf(int k);
    return (k == 0) ? 480 : (k == 1) ? 60 : 6;
  endfunction
  function automatic int waitOf(int k);
    return (k == 0) ? 70 : (k == 3) ? 9 : 0;
  endfunction
  function automatic int tailOf(int k);
    return (k == 0) ? 410 : (k == 1) ? 10 : (k == 2) ? 64 : 55;
  endfunction

  // pat 0: no device pull; 1: pull around the sample instant; 2: pull ending 4 us before it
  task automatic runSlot(input int op, input bit b, input int pat, input bit poke);
    int kind, lowUs, sUs, totUs, fromUs, toUs, expBit;
    int lowA, lowB, doneA, doneB, bitA, bitB;
    string tag;
    kind  = kindOf(op, b);
    lowUs = lowOf(kind);
    sUs   = lowUs + waitOf(kind);
    totUs = sUs + tailOf(kind);
    fromUs = 0; toUs = 0;
    if (pat == 1) begin fromUs = sUs - 4; toUs = sUs + 4; end
    if (pat == 2) begin fromUs = lowUs;   toUs = sUs - 4; end
    expBit = (kind == 0 || kind == 3) ? ((pat == 1) ? 0 : 1) : 0;
    if (op == 2)        tag = "R7";
    else if (kind == 0) tag = "R5";
    else if (kind == 1) tag = "R3";
    else if (kind == 2) tag = "R2";
    else                tag = "R4";
    lowA = 0; lowB = 0; doneA = -1; doneB = -1; bitA = 0; bitB = 0;

    @(negedge clk);
    cmdOp = 2'(op); cmdBit = b; cmdValid = 1'b1;
    for (int k = 0; k < 8000 && !(doneA >= 0 && doneB >= 0); k++) begin
      @(negedge clk);
      cmdValid = poke && k >= 10 && k < 20;
      if (poke) begin cmdOp = 2'b00; cmdBit = 1'b1; end
      pullA = (k >= fromUs*UA) && (k < toUs*UA);
      pullB = (k >= fromUs*UB) && (k < toUs*UB);
      if (driveA) lowA++;
      if (driveB) lowB++;
      if (k == 1) check(readyA == 1'b0, "R9 ready low while busy", int'(readyA), 0);
      if (doneA >= 0 && k == doneA + 1)
        check(rspValidA == 1'b0, "R10 done lasts one cycle", int'(rspValidA), 0);
      if (doneA < 0 && rspValidA) begin
        doneA = k; bitA = int'(rspBitA);
        check(readyA == 1'b1, "R10 ready back with done", int'(readyA), 1);
      end
      if (doneB < 0 && rspValidB) begin doneB = k; bitB = int'(rspBitB); end
    end
    pullA = 1'b0; pullB = 1'b0; cmdValid = 1'b0;
    check(lowA == lowUs*UA, {tag, " low window"}, lowA, lowUs*UA);
    check(doneA == totUs*UA, {tag, " slot length"}, doneA, totUs*UA);
    check(bitA == expBit, (kind == 0) ? "R6 presence result" : {tag, " result bit"}, bitA, expBit);
    check(lowB == lowUs*UB, "R8 scaled low window", lowB, lowUs*UB);
    check(doneB == totUs*UB, "R8 scaled slot length", doneB, totUs*UB);
    check(bitB == expBit, "R8 scaled result bit", bitB, expBit);
    if (poke) begin
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        check(driveA == 1'b0 && driveB == 1'b0, "R9 request while busy ignored",
              int'(driveA) + int'(driveB), 0);
      end
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(driveA == 1'b0 && driveB == 1'b0, "R1 line released in reset", int'(driveA), 0);
    rst = 1'b0;
    @(negedge clk);
    check(driveA == 1'b0, "R1 line released after reset", int'(driveA), 0);
    check(readyA == 1'b1 && readyB == 1'b1, "R1 ready after reset", int'(readyA), 1);
    check(rspValidA == 1'b0, "R1 no done after reset", int'(rspValidA), 0);
    check(driveB == 1'b0 && rspValidB == 1'b0, "R11 scaled instance idle", int'(driveB), 0);
    for (int op = 0; op < 4; op++)
      for (int b = 0; b < 2; b++)
        for (int pat = 0; pat < 3; pat++)
          runSlot(op, b[0], pat, 1'b0);
    runSlot(1, 1'b0, 1, 1'b1);
    runSlot(3, 1'b1, 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule